// File: doc/BRIEF.md
# Relocating Effective Address Generator

This block forms the word address for a memory operand in a 65-family style processor whose registers are all 32 bits wide. It is given an addressing-mode code, the operand word from the instruction, the three index registers (X, Y and a third register W), a 32-bit direct-page base and two 32-bit bank offsets: one for instruction-side requests and one for data-side requests. Because every bank register is a full 32-bit offset and not a page selector, the 4G-word space has no bank boundaries. A program and its private data can be placed anywhere and still be coded as if they start at word zero.

Direct-page modes add the direct-page base, an optional index and the selected bank offset to the operand. Long modes skip both the bank offset and the direct-page base, so an instruction can reach memory outside the running program. The immediate code produces no address. Every sum wraps modulo 2^32. The result is registered: it appears one clock after a valid request and is held until the next valid request.

Top module: `ea_gen`

## Requirements
- R1: While rst_n is low, out_valid_o, addr_valid_o and bank_used_o are 0 and addr_o is 0.
- R2: out_valid_o is high exactly one cycle after a cycle in which in_valid is high. In a cycle with in_valid low, addr_o, addr_valid_o and bank_used_o keep their previous values, whatever the other inputs do.
- R3: Mode code 0 (direct page) gives addr_o = operand + direct-page base + bank offset.
- R4: Mode code 1 (direct page indexed by X) gives operand + direct-page base + X + bank offset.
- R5: Mode code 2 (direct page indexed by Y) gives operand + direct-page base + Y + bank offset.
- R6: Mode code 3 (direct page indexed by W) gives operand + direct-page base + W + bank offset.
- R7: Mode code 4 (long) gives addr_o = operand. It uses neither the bank offset nor the direct-page base.
- R8: Mode code 5 (long indexed by X) gives addr_o = operand + X. It uses neither the bank offset nor the direct-page base.
- R9: Mode code 6 (immediate) and the spare code 7 give addr_valid_o = 0, bank_used_o = 0 and addr_o = 0.
- R10: In codes 0 to 3, fetch_i = 1 selects the program bank offset pbank_i, and fetch_i = 0 selects the data bank offset dbank_i.
- R11: Every sum wraps modulo 2^32. There is no carry out and no error on overflow.
- R12: bank_used_o is 1 for codes 0 to 3 and 0 for all other codes. addr_valid_o is 1 for codes 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request present this cycle |
| mode_i | input | 3 | Addressing-mode code 0..7 |
| fetch_i | input | 1 | 1 = instruction-side request, 0 = data-side request |
| operand_i | input | 32 | Operand word from the instruction |
| x_i | input | 32 | X index register |
| y_i | input | 32 | Y index register |
| w_i | input | 32 | W index register |
| dp_i | input | 32 | Direct-page base |
| pbank_i | input | 32 | Program bank offset |
| dbank_i | input | 32 | Data bank offset |
| out_valid_o | output | 1 | Result registered from the previous cycle's request |
| addr_valid_o | output | 1 | The result is a memory address |
| bank_used_o | output | 1 | A bank offset was added |
| addr_o | output | 32 | Word address |

## Verification
The assertions assume that in_valid is a known level at every clock edge. They also assume that mode_i and the register inputs are known whenever in_valid is high. All eight mode codes are legal, so no input restriction applies to the code itself. The stimulus changes inputs only on the falling edge. It holds known values throughout, and it scrambles the operand and register inputs during idle cycles, which tests that those cycles have no effect. Operands and offsets are drawn at random, and directed values are placed near 2^32 so that each sum wraps.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int unsigned EA_MODE_W = 3;

  typedef enum logic [EA_MODE_W-1:0] {
    EA_DP    = 3'd0,
    EA_DPX   = 3'd1,
    EA_DPY   = 3'd2,
    EA_DPW   = 3'd3,
    EA_LONG  = 3'd4,
    EA_LONGX = 3'd5,
    EA_IMM   = 3'd6,
    EA_SPARE = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_X    = 2'd1,
    IDX_Y    = 2'd2,
    IDX_W    = 2'd3
  } ea_idx_e;

  typedef struct packed {
    logic    addr_ok;
    logic    use_dp;
    logic    use_bank;
    ea_idx_e idx_sel;
  } ea_ctrl_t;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [EA_MODE_W-1:0] mode_i,
  output ea_ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o = '{addr_ok: 1'b0, use_dp: 1'b0, use_bank: 1'b0, idx_sel: IDX_NONE};
    unique case (mode_i)
      EA_DP:    ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b1, use_bank: 1'b1, idx_sel: IDX_NONE};
      EA_DPX:   ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b1, use_bank: 1'b1, idx_sel: IDX_X};
      EA_DPY:   ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b1, use_bank: 1'b1, idx_sel: IDX_Y};
      EA_DPW:   ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b1, use_bank: 1'b1, idx_sel: IDX_W};
      EA_LONG:  ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b0, use_bank: 1'b0, idx_sel: IDX_NONE};
      EA_LONGX: ctrl_o = '{addr_ok: 1'b1, use_dp: 1'b0, use_bank: 1'b0, idx_sel: IDX_X};
      default:  ctrl_o = '{addr_ok: 1'b0, use_dp: 1'b0, use_bank: 1'b0, idx_sel: IDX_NONE};
    endcase
  end

endmodule

// File: rtl/ea_index_mux.sv
module ea_index_mux
  import ea_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  ea_idx_e       sel_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] w_i,
  output logic [AW-1:0] idx_o
);

  always_comb begin
    unique case (sel_i)
      IDX_X:   idx_o = x_i;
      IDX_Y:   idx_o = y_i;
      IDX_W:   idx_o = w_i;
      default: idx_o = '0;
    endcase
  end

endmodule

// File: rtl/ea_offset_sel.sv
module ea_offset_sel #(
  parameter int unsigned AW = 32
) (
  input  logic          use_dp_i,
  input  logic          use_bank_i,
  input  logic          fetch_i,
  input  logic [AW-1:0] dp_i,
  input  logic [AW-1:0] pbank_i,
  input  logic [AW-1:0] dbank_i,
  output logic [AW-1:0] dp_off_o,
  output logic [AW-1:0] bank_off_o
);

  logic [AW-1:0] bank_pick;

  always_comb begin
    bank_pick  = fetch_i ? pbank_i : dbank_i;
    dp_off_o   = use_dp_i   ? dp_i      : '0;
    bank_off_o = use_bank_i ? bank_pick : '0;
  end

endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int unsigned AW      = 32,
  parameter int unsigned N_TERMS = 4
) (
  input  logic [N_TERMS-1:0][AW-1:0] terms_i,
  output logic [AW-1:0]              sum_o
);

  logic [N_TERMS-1:0][AW-1:0] partial;

  assign partial[0] = terms_i[0];

  for (genvar g = 1; g < N_TERMS; g++) begin : g_chain
    assign partial[g] = partial[g-1] + terms_i[g];
  end

  assign sum_o = partial[N_TERMS-1];

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [EA_MODE_W-1:0] mode_i,
  input  logic                 fetch_i,
  input  logic [AW-1:0]        operand_i,
  input  logic [AW-1:0]        x_i,
  input  logic [AW-1:0]        y_i,
  input  logic [AW-1:0]        w_i,
  input  logic [AW-1:0]        dp_i,
  input  logic [AW-1:0]        pbank_i,
  input  logic [AW-1:0]        dbank_i,
  output logic                 out_valid_o,
  output logic                 addr_valid_o,
  output logic                 bank_used_o,
  output logic [AW-1:0]        addr_o
);

  localparam int unsigned N_TERMS = 4;

  ea_ctrl_t                   ctrl;
  logic [AW-1:0]              idx, dp_off, bank_off, sum;
  logic [N_TERMS-1:0][AW-1:0] terms;

  logic          ov_d, av_d, bu_d;
  logic [AW-1:0] addr_d;
  logic          ld_en;

  ea_mode_dec u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  ea_index_mux #(.AW(AW)) u_idx (
    .sel_i (ctrl.idx_sel),
    .x_i   (x_i),
    .y_i   (y_i),
    .w_i   (w_i),
    .idx_o (idx)
  );

  ea_offset_sel #(.AW(AW)) u_off (
    .use_dp_i   (ctrl.use_dp),
    .use_bank_i (ctrl.use_bank),
    .fetch_i    (fetch_i),
    .dp_i       (dp_i),
    .pbank_i    (pbank_i),
    .dbank_i    (dbank_i),
    .dp_off_o   (dp_off),
    .bank_off_o (bank_off)
  );

  assign terms = {bank_off, idx, dp_off, operand_i};

  ea_sum #(.AW(AW), .N_TERMS(N_TERMS)) u_sum (
    .terms_i (terms),
    .sum_o   (sum)
  );

  // Next-state logic. The clock enable holds the result while no request is present.
  always_comb begin
    ld_en  = in_valid;
    ov_d   = in_valid;
    av_d   = addr_valid_o;
    bu_d   = bank_used_o;
    addr_d = addr_o;
    if (ld_en) begin
      av_d   = ctrl.addr_ok;
      bu_d   = ctrl.use_bank;
      addr_d = ctrl.addr_ok ? sum : '0;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o  <= 1'b0;
      addr_valid_o <= 1'b0;
      bank_used_o  <= 1'b0;
      addr_o       <= '0;
    end else begin
      out_valid_o  <= ov_d;
      addr_valid_o <= av_d;
      bank_used_o  <= bu_d;
      addr_o       <= addr_d;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid_o && !addr_valid_o && !bank_used_o && addr_o == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_o);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid_o);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(addr_o) && $stable(addr_valid_o) && $stable(bank_used_o)));

  a_r7_long_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_i == EA_LONG) |=> (addr_o == $past(operand_i) && !bank_used_o));

  a_r8_long_x: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_i == EA_LONGX) |=> (addr_o == $past(operand_i) + $past(x_i)));

  a_r9_no_address: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_i >= EA_IMM) |=> (!addr_valid_o && !bank_used_o && addr_o == '0));

  a_r12_dp_banked: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_i < EA_LONG) |=> (bank_used_o && addr_valid_o));

endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;

  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    mode_i = '0;
  logic          fetch_i = 1'b0;
  logic [AW-1:0] operand_i = '0, x_i = '0, y_i = '0, w_i = '0;
  logic [AW-1:0] dp_i = '0, pbank_i = '0, dbank_i = '0;
  logic          out_valid_o, addr_valid_o, bank_used_o;
  logic [AW-1:0] addr_o;

  always #2 clk = ~clk;

  ea_gen #(.AW(AW)) u_ea_gen (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .mode_i (mode_i),
    .fetch_i (fetch_i), .operand_i (operand_i), .x_i (x_i), .y_i (y_i),
    .w_i (w_i), .dp_i (dp_i), .pbank_i (pbank_i), .dbank_i (dbank_i),
    .out_valid_o (out_valid_o), .addr_valid_o (addr_valid_o),
    .bank_used_o (bank_used_o), .addr_o (addr_o)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          av;
    logic          bu;
    string         req;
  } exp_t;

  exp_t          sb[$];
  int            n_checks = 0;
  int            n_fail = 0;
  bit            have_last = 0;
  logic [AW-1:0] last_addr;
  logic          last_av, last_bu;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic [2:0] m, input logic f,
      input logic [AW-1:0] op, x, y, w, dp, pb, db, input string req);
    exp_t e;
    logic [AW-1:0] bk;
    bk = f ? pb : db;    // R10
    e.req = req;
    case (m)
      3'd0: begin e.addr = op + dp + bk;     e.av = 1; e.bu = 1; end
      3'd1: begin e.addr = op + dp + x + bk; e.av = 1; e.bu = 1; end
      3'd2: begin e.addr = op + dp + y + bk; e.av = 1; e.bu = 1; end
      3'd3: begin e.addr = op + dp + w + bk; e.av = 1; e.bu = 1; end
      3'd4: begin e.addr = op;               e.av = 1; e.bu = 0; end
      3'd5: begin e.addr = op + x;           e.av = 1; e.bu = 0; end
      default: begin e.addr = '0;            e.av = 0; e.bu = 0; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic f,
      input logic [AW-1:0] op, x, y, w, dp, pb, db, input string req);
    @(negedge clk);
    in_valid = 1'b1; mode_i = m; fetch_i = f; operand_i = op;
    x_i = x; y_i = y; w_i = w; dp_i = dp; pbank_i = pb; dbank_i = db;
    sb.push_back(model(m, f, op, x, y, w, dp, pb, db, req));
  endtask

  // Idle cycle: every other input is scrambled to show it is ignored (R2)
  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; mode_i = 3'($urandom); fetch_i = 1'($urandom);
    operand_i = $urandom; x_i = $urandom; y_i = $urandom; w_i = $urandom;
    dp_i = $urandom; pbank_i = $urandom; dbank_i = $urandom;
  endtask

  // Monitor: pops the scoreboard whenever a result is presented
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(addr_o == e.addr, e.req, "addr", addr_o, e.addr);
          check(addr_valid_o == e.av, "R12", "addr_valid", 32'(addr_valid_o), 32'(e.av));
          check(bank_used_o == e.bu, "R12", "bank_used", 32'(bank_used_o), 32'(e.bu));
          last_addr = e.addr; last_av = e.av; last_bu = e.bu; have_last = 1;
        end
      end else if (have_last) begin
        check(addr_o == last_addr && addr_valid_o == last_av && bank_used_o == last_bu,
              "R2", "hold while idle", addr_o, last_addr);
      end
    end
  end

  initial begin
    #(4 * 150000);
    check(1'b0, "watchdog", "timeout", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held clear during reset
    check(!out_valid_o && !addr_valid_o && !bank_used_o && addr_o == '0,
          "R1", "reset state", addr_o, '0);
    rst_n = 1'b1;

    send(3'd0, 1'b0, 32'h100, 32'h1, 32'h2, 32'h3, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R3");
    send(3'd1, 1'b0, 32'h100, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R4");
    send(3'd2, 1'b0, 32'h100, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R5");
    send(3'd3, 1'b0, 32'h100, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R6");
    send(3'd4, 1'b1, 32'hABCD, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R7");
    send(3'd5, 1'b0, 32'hABCD, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R8");
    send(3'd6, 1'b0, 32'hABCD, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R9");
    send(3'd7, 1'b1, 32'hABCD, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R9");
    send(3'd1, 1'b1, 32'h100, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R10");
    send(3'd3, 1'b0, 32'h100, 32'h11, 32'h22, 32'h33, 32'h1000, 32'h5000_0000, 32'h0700_0000, "R10");
    idle(); idle(); idle();
    // R11: sums that wrap past the top of the address space
    send(3'd0, 1'b0, 32'hFFFF_FFF0, 32'h0, 32'h0, 32'h0, 32'h10, 32'h0, 32'h5, "R11");
    send(3'd2, 1'b1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h3, 32'h0, "R11");
    send(3'd5, 1'b0, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, "R11");
    idle();

    for (int i = 0; i < 400; i++) begin
      send(3'($urandom), 1'($urandom), $urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, "R11");
      if (($urandom % 4) == 0) idle();
    end
    idle(); idle(); idle();
    check(sb.size() == 0, "R2", "results outstanding", 32'(sb.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule